// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an 8-bit storage register with four operations. On each rising clock edge it can keep its contents, shift toward the high end, shift toward the low end, or capture a byte. Two select inputs pick the operation. The register has one 8-bit tri-state port. The block captures bytes from that port and also drives its contents back onto it. Two active-low enables decide whether the contents are driven onto the port.

Two serial outputs always show the two end stages, whatever the enables are. This allows several copies to be chained or read out one bit at a time while the shared port is used by other agents. An active-low clear empties the register at once, without waiting for the clock. Neither a clear nor a clocked operation depends on whether the port is being driven.

Top module: `univ_shift_reg`

## Requirements
- R1: While `clr_n` is low, all bits read 0 within the same clock phase, with no rising edge needed.
- R2: With `{sel1,sel0}` = 2'b00 (hold), the contents do not change on a rising edge.
- R3: With `{sel1,sel0}` = 2'b01, a rising edge moves bit n into bit n+1 and loads bit 0 from `ser_r_in`.
- R4: With `{sel1,sel0}` = 2'b10, a rising edge moves bit n+1 into bit n and loads bit 7 from `ser_l_in`.
- R5: With `{sel1,sel0}` = 2'b11, a rising edge captures the byte present on `data_io`.
- R6: When both `oe_a_n` and `oe_b_n` are low and the mode is not 2'b11, `data_io` carries the register contents.
- R7: When `oe_a_n` or `oe_b_n` is high, the block releases `data_io`, so an external driver sets its value.
- R8: In mode 2'b11 the block releases `data_io` even when both enables are low.
- R9: `q_first` always shows bit 0 and `q_last` always shows bit 7, including while `data_io` is released.
- R10: Shifting, capturing and clearing work the same while `data_io` is released.
- R11: While `clr_n` is low, rising edges in every mode, capture included, leave the contents at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel0 | input | 1 | Mode select, low bit |
| sel1 | input | 1 | Mode select, high bit |
| oe_a_n | input | 1 | Port enable A, active low |
| oe_b_n | input | 1 | Port enable B, active low |
| ser_r_in | input | 1 | Serial fill for bit 0 during an upward shift |
| ser_l_in | input | 1 | Serial fill for bit 7 during a downward shift |
| data_io | inout | 8 | Shared tri-state byte port |
| q_first | output | 1 | Always-driven copy of bit 0 |
| q_last | output | 1 | Always-driven copy of bit 7 |

## Verification
A chained table starts from a captured 0xA5. It then shifts upward with both fill values, shifts downward with both fill values, holds, captures again, and holds while the serial inputs toggle. Each result depends on the one before it, so an error in direction or in fill source stays visible in every later read-back. Directed cases look at the port from an external driver while one enable is high and in capture mode. In those cases a wrong release shows as a corrupted read. Other directed cases shift and capture while the port is released, and clear the register in the middle of a cycle, to separate a clocked clear from an asynchronous one.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_CAPT = 2'b11
  } usr_mode_e;

  localparam int unsigned USR_DEF_W = 8;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic      sel0,
  input  logic      sel1,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output usr_mode_e mode,
  output logic      capt_evt,
  output logic      pins_en
);

  logic both_en;

  always_comb begin
    mode = usr_mode_e'({sel1, sel0});
  end

  // capture mode releases the port so outside data can be sampled
  assign capt_evt = (mode == MODE_CAPT);
  assign both_en  = ~oe_a_n & ~oe_b_n;
  assign pins_en  = both_en & ~capt_evt;

endmodule

// File: rtl/usr_reg_core.sv
module usr_reg_core
  import usr_pkg::*;
#(
  parameter int unsigned W = USR_DEF_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  usr_mode_e    mode,
  input  logic         ser_r,
  input  logic         ser_l,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] q
);

  localparam int unsigned TOP = W - 1;

  function automatic logic [W-1:0] move_up(input logic [W-1:0] v, input logic fill);
    move_up = {v[TOP-1:0], fill};
  endfunction

  function automatic logic [W-1:0] move_down(input logic [W-1:0] v, input logic fill);
    move_down = {fill, v[TOP:1]};
  endfunction

  function automatic logic [W-1:0] next_val(input usr_mode_e m, input logic [W-1:0] v,
                                            input logic fr, input logic fl,
                                            input logic [W-1:0] pins);
    case (m)
      MODE_UP:   next_val = move_up(v, fr);
      MODE_DOWN: next_val = move_down(v, fl);
      MODE_CAPT: next_val = pins;
      default:   next_val = v;
    endcase
  endfunction

  logic [W-1:0] q_nx;

  assign q_nx = next_val(mode, q, ser_r, ser_l, pin_in);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nx;
  end

endmodule

// File: rtl/usr_pin_drv.sv
module usr_pin_drv #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] q,
  output logic [W-1:0] pin_in,
  inout  wire  [W-1:0] pins
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign pins[i] = en ? q[i] : 1'bz;
    end
  endgenerate

  assign pin_in = pins;

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int unsigned W = USR_DEF_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         sel0,
  input  logic         sel1,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         ser_r_in,
  input  logic         ser_l_in,
  inout  wire  [W-1:0] data_io,
  output logic         q_first,
  output logic         q_last
);

  usr_mode_e    mode;
  logic         capt_evt;
  logic         pins_en;
  logic [W-1:0] pin_in;
  logic [W-1:0] q_state;

  usr_mode_dec u_dec (
    .sel0     (sel0),
    .sel1     (sel1),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .mode     (mode),
    .capt_evt (capt_evt),
    .pins_en  (pins_en)
  );

  usr_reg_core #(.W(W)) u_core (
    .clk    (clk),
    .clr_n  (clr_n),
    .mode   (mode),
    .ser_r  (ser_r_in),
    .ser_l  (ser_l_in),
    .pin_in (pin_in),
    .q      (q_state)
  );

  usr_pin_drv #(.W(W)) u_pins (
    .en     (pins_en),
    .q      (q_state),
    .pin_in (pin_in),
    .pins   (data_io)
  );

  assign q_first = q_state[0];
  assign q_last  = q_state[W-1];

endmodule

// File: rtl/usr_sr_chk.sv
module usr_sr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         sel0,
  input logic         sel1,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic         ser_r_in,
  input logic         ser_l_in,
  input logic [W-1:0] data_io,
  input logic [W-1:0] q_state,
  input logic         capt_evt,
  input logic         q_first,
  input logic         q_last
);

  // evaluated only while clear is held
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (clr_n)
    1'b1 |-> (q_state == '0 && !q_first && !q_last));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel1, sel0} == 2'b00) |=> $stable(q_state));

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel1, sel0} == 2'b01) |=> (q_state == {$past(q_state[W-2:0]), $past(ser_r_in)}));

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel1, sel0} == 2'b10) |=> (q_state == {$past(ser_l_in), $past(q_state[W-1:1])}));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!clr_n)
    capt_evt |=> (q_state == $past(data_io)));

  assert_port_drive_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_a_n && !oe_b_n && {sel1, sel0} != 2'b11) |-> (data_io == q_state));

  assert_last_tap_R9: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel1, sel0} == 2'b01) |=> (q_last == $past(q_state[W-2])));

  assert_first_tap_R9: assert property (@(posedge clk) disable iff (!clr_n)
    ({sel1, sel0} == 2'b10) |=> (q_first == $past(q_state[1])));

endmodule

bind univ_shift_reg usr_sr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .sel0     (sel0),
  .sel1     (sel1),
  .oe_a_n   (oe_a_n),
  .oe_b_n   (oe_b_n),
  .ser_r_in (ser_r_in),
  .ser_l_in (ser_l_in),
  .data_io  (data_io),
  .q_state  (q_state),
  .capt_evt (capt_evt),
  .q_first  (q_first),
  .q_last   (q_last)
);

// File: tb/tb_univ_shift_reg.sv
`timescale 1ns/1ps
module tb_univ_shift_reg;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       sel0 = 1'b0, sel1 = 1'b0;
  logic       oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic       ser_r_in = 1'b0, ser_l_in = 1'b0;
  logic       tb_en = 1'b0;
  logic [7:0] tb_drv = 8'h00;
  wire  [7:0] data_io;
  logic       q_first, q_last;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign data_io = tb_en ? tb_drv : 8'bzzzzzzzz;

  univ_shift_reg dut (
    .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_r_in(ser_r_in), .ser_l_in(ser_l_in),
    .data_io(data_io), .q_first(q_first), .q_last(q_last)
  );

  // {mode, fill_r, fill_l, byte on port, expected contents}
  typedef struct packed {
    logic [1:0] md;
    logic       fr;
    logic       fl;
    logic [7:0] din;
    logic [7:0] exp_q;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R5 capture
    '{2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R3 up, fill 1
    '{2'b01, 1'b0, 1'b0, 8'h00, 8'h96},  // R3 up, fill 0
    '{2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},  // R4 down, fill 1
    '{2'b10, 1'b0, 1'b0, 8'h00, 8'h65},  // R4 down, fill 0
    '{2'b00, 1'b1, 1'b1, 8'h00, 8'h65},  // R2 hold
    '{2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R5 capture
    '{2'b10, 1'b1, 1'b0, 8'h00, 8'h1E},  // R4 down
    '{2'b01, 1'b1, 1'b0, 8'h00, 8'h3D},  // R3 up
    '{2'b00, 1'b1, 1'b1, 8'h00, 8'h3D}   // R2 hold, serial inputs toggled
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one clocked step, then return to hold with port driven by the block
  task automatic step(input logic [1:0] md, input logic fr, input logic fl,
                      input logic [7:0] din);
    @(negedge clk);
    {sel1, sel0} = md;
    ser_r_in = fr;
    ser_l_in = fl;
    tb_drv = din;
    tb_en = (md == 2'b11);
    @(posedge clk);
    #1;
    {sel1, sel0} = 2'b00;
    tb_en = 1'b0;
    #1;
  endtask

  task automatic read_all(input string tag, input logic [7:0] exp);
    check(tag, data_io, exp);
    check({tag, " R9 taps"}, {6'd0, q_last, q_first}, {6'd0, exp[7], exp[0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    read_all("R1 reset state", 8'h00);
    @(negedge clk);
    clr_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].md, VEC[k].fr, VEC[k].fl, VEC[k].din);
      read_all($sformatf("R2 R3 R4 R5 vector %0d", k), VEC[k].exp_q);
    end

    // R7: enable A high, outside byte seen unchanged
    @(negedge clk);
    oe_a_n = 1'b1; tb_drv = 8'h5A; tb_en = 1'b1;
    #1 check("R7 oe_a_n high", data_io, 8'h5A);
    oe_a_n = 1'b0; oe_b_n = 1'b1; tb_drv = 8'hC3;
    #1 check("R7 oe_b_n high", data_io, 8'hC3);
    tb_en = 1'b0; oe_b_n = 1'b0;
    #1 read_all("R2 contents kept", 8'h3D);

    // R8: capture mode releases port with both enables low (no edge taken)
    @(negedge clk);
    {sel1, sel0} = 2'b11; tb_drv = 8'h69; tb_en = 1'b1;
    #1 check("R8 capture releases port", data_io, 8'h69);
    {sel1, sel0} = 2'b00; tb_en = 1'b0;
    #1 read_all("R8 contents kept", 8'h3D);

    // R10: operate while port released, taps still visible
    oe_a_n = 1'b1;
    step(2'b01, 1'b0, 1'b0, 8'h00);  // 7A
    check("R10 R9 tap last while released", {7'd0, q_last}, 8'h00);
    step(2'b01, 1'b0, 1'b0, 8'h00);  // F4
    check("R10 R9 tap last while released", {7'd0, q_last}, 8'h01);
    step(2'b11, 1'b0, 1'b0, 8'h81);
    check("R10 R9 taps after capture", {6'd0, q_last, q_first}, 8'h03);
    oe_a_n = 1'b0;
    #1 read_all("R10 capture while released", 8'h81);

    // R1: asynchronous clear mid-cycle, no edge between
    @(negedge clk);
    #1 clr_n = 1'b0;
    #1 read_all("R1 async clear", 8'h00);

    // R11: clear held across a capture edge
    @(negedge clk);
    {sel1, sel0} = 2'b11; tb_drv = 8'hFF; tb_en = 1'b1;
    @(posedge clk);
    #1 {sel1, sel0} = 2'b00; tb_en = 1'b0;
    #1 read_all("R11 clear beats capture", 8'h00);
    step(2'b10, 1'b0, 1'b1, 8'h00);
    read_all("R11 clear beats shift", 8'h00);
    @(negedge clk);
    clr_n = 1'b1;
    step(2'b10, 1'b0, 1'b1, 8'h00);
    read_all("R4 after clear release", 8'h80);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule